// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block drives an external 14-bit parallel sampling converter from a synchronous system clock. It owns the converter's active-low start strobe and reads the converter's active-low busy line, which stays low for the whole conversion. It captures the parallel result once that result is safe to read and hands each sample downstream as a single-cycle valid pulse with a 16-bit word. A conversion begins when software raises a trigger pulse, or when the programmed sample interval has elapsed in free-running mode.

All analog timing rules are turned into clock-cycle counts at elaboration time: the minimum spacing between start edges, the longest allowed conversion and the settling delay after busy rises. The strobe comes straight from a flop, so its falling edge, which sets the sampling instant, is free of glitches. A trigger that arrives while a conversion runs is held and served once the spacing rule allows it. It never restarts the running conversion. If busy does not complete its low phase in time, the block raises an error pulse and goes back to waiting for the next request.

The converter codes its result in two's complement. A parameter selects how the 16-bit output word is formed: either the sign is extended into the top bits, or the result is moved to offset binary.

Top module: `adc_conv_ctrl`

## Requirements
- R1: A synchronous reset, taken in any state and including mid-conversion, drives the strobe high and leaves smp_valid and timeout_err low. No sample or error from the aborted conversion appears after reset is released.
- R2: No falling strobe edge occurs while the synchronized busy line shows a conversion in progress. A trigger that arrives during a conversion, or while busy is stuck low, is held until busy returns high, and it is then served.
- R3: Each strobe low pulse lasts exactly START_LOW_CYC clock cycles (2 by default).
- R4: Consecutive falling strobe edges are at least MIN_GAP_CYC = ceil(454 ns / clock period) cycles apart, which is 91 cycles at 5 ns. A request held pending fires exactly at that spacing.
- R5: smp_valid rises on the (SETTLE_CYC + 3)th rising clock edge after busy returns high. This is 2 synchronizer stages, plus 1 detect cycle, plus SETTLE_CYC = ceil(20 ns / clock period) = 4 cycles, for 7 edges in total. The captured word is the one present after busy rose, not the word from before.
- R6: smp_valid is high for exactly one cycle per conversion. With OFFSET_BIN = 0, smp_data is the 14-bit two's complement result sign-extended to 16 bits, so the numeric value is kept.
- R7: With OFFSET_BIN = 1, smp_data equals the signed result plus 8192. Bit 13 is the inverted sign, bits 12:0 are unchanged and bits 15:14 are zero.
- R8: With auto_en high, falling strobe edges recur every max(sample_interval, MIN_GAP_CYC) cycles, counted from one falling edge to the next.
- R9: If busy has not gone low and come back high within CONV_CYC + TMO_MARGIN_CYC cycles of the strobe falling edge (80 + 8 by default), timeout_err pulses for one cycle. That pulse comes (CONV_CYC + TMO_MARGIN_CYC + 1) cycles after the falling edge. No sample is produced, and the block accepts the next request.
- R10: From idle, with the spacing met, a one-cycle sw_trig drives the strobe low after the first rising clock edge that samples the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| auto_en | input | 1 | Free-running mode: starts a conversion each time the sample interval elapses |
| sample_interval | input | CNT_W | Free-running spacing, in clock cycles, between start edges |
| sw_trig | input | 1 | Software conversion request; it is held until served |
| adc_start_n | output | 1 | Converter start strobe, active low, driven from a flop |
| adc_busy_n | input | 1 | Converter busy line, asynchronous; low while a conversion runs |
| adc_data | input | DATA_W | Parallel conversion result, two's complement |
| smp_valid | output | 1 | One-cycle marker of a new sample |
| smp_data | output | OUT_W | Formatted sample word |
| timeout_err | output | 1 | One-cycle pulse when a conversion overruns its window |

## Verification
The assertions assume that the converter pulls busy low soon after a strobe edge and holds it low for at least a few clock cycles. They also assume that busy and the data word change together, and that the data word does not move while busy is high. The bench models the converter with exactly those properties. It drops busy 1 ns after it sees the strobe fall, holds it low for 12 to 60 cycles, and then changes the data word and raises busy in the same step. Before the rise it places a decoy word on the bus, so a capture at the wrong point would show up. The timeout cases break this contract on purpose, one with busy never falling and one with busy never rising. They are the only cases where busy stays low past the window.

// File: rtl/adc_ctrl_pkg.sv
`timescale 1ns/1ps
package adc_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_LOW,
        ST_WAIT_LOW,
        ST_WAIT_HIGH,
        ST_SETTLE,
        ST_CAPTURE
    } ctrl_state_e;

endpackage

// File: rtl/adc_sync2.sv
`timescale 1ns/1ps
// Two-stage synchronizer for one asynchronous level input.
module adc_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);

    logic [1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[0], d_i};
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= {2{RST_VAL}};
        else     stage_q <= stage_d;
    end

    assign q_o = stage_q[1];

endmodule

// File: rtl/adc_pacer.sv
`timescale 1ns/1ps
// Spacing between start edges: one counter serves both the free-running
// interval and the minimum spacing between conversions.
module adc_pacer #(
    parameter int CNT_W   = 16,
    parameter int MIN_GAP = 91
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en,
    input  logic [CNT_W-1:0] interval_i,
    input  logic             trig_i,
    input  logic             issue_i,
    output logic             fire_ok_o
);

    localparam logic [CNT_W-1:0] GAP_L = CNT_W'(MIN_GAP);
    localparam logic [CNT_W-1:0] SAT_L = '1;
    localparam logic [CNT_W-1:0] ONE_L = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] since;
        logic             pend;
    } pace_t;

    pace_t q, d;
    logic  spaced, due;

    always_comb begin
        spaced    = (q.since >= GAP_L);
        due       = q.pend || trig_i || (auto_en && (q.since >= interval_i));
        fire_ok_o = spaced && due;
        d = q;
        if (issue_i) begin
            d.since = ONE_L;
            d.pend  = 1'b0;
        end else begin
            if (q.since != SAT_L) d.since = q.since + ONE_L;
            if (trig_i)           d.pend  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.since <= SAT_L;
            q.pend  <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/adc_fmt.sv
`timescale 1ns/1ps
// Widens the two's complement result to the output word.
module adc_fmt #(
    parameter int DATA_W     = 14,
    parameter int OUT_W      = 16,
    parameter bit OFFSET_BIN = 1'b0
) (
    input  logic [DATA_W-1:0] raw_i,
    output logic [OUT_W-1:0]  word_o
);

    localparam int EXT_W = OUT_W - DATA_W;

    generate
        if (OFFSET_BIN) begin : g_offset
            assign word_o = {{EXT_W{1'b0}}, ~raw_i[DATA_W-1], raw_i[DATA_W-2:0]};
        end else begin : g_signext
            assign word_o = {{EXT_W{raw_i[DATA_W-1]}}, raw_i};
        end
    endgenerate

endmodule

// File: rtl/adc_conv_ctrl.sv
`timescale 1ns/1ps
module adc_conv_ctrl #(
    parameter int DATA_W         = 14,
    parameter int OUT_W          = 16,
    parameter int CNT_W          = 16,
    parameter int CLK_PERIOD_PS  = 5000,
    parameter int CONV_MAX_PS    = 400000,
    parameter int THROUGHPUT_PS  = 454000,
    parameter int DATA_VALID_PS  = 20000,
    parameter int TMO_MARGIN_CYC = 8,
    parameter int START_LOW_CYC  = 2,
    parameter bit OFFSET_BIN     = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_en,
    input  logic [CNT_W-1:0]  sample_interval,
    input  logic              sw_trig,
    output logic              adc_start_n,
    input  logic              adc_busy_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              smp_valid,
    output logic [OUT_W-1:0]  smp_data,
    output logic              timeout_err
);
    import adc_ctrl_pkg::*;

    localparam int SETTLE_CYC  = (DATA_VALID_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int CONV_CYC    = (CONV_MAX_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int MIN_GAP_CYC = (THROUGHPUT_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int TMO_CYC     = CONV_CYC + TMO_MARGIN_CYC;

    localparam logic [CNT_W-1:0] LOW_L    = CNT_W'(START_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_L = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_L    = CNT_W'(TMO_CYC);
    localparam logic [CNT_W-1:0] ONE_L    = CNT_W'(1);

    typedef struct packed {
        ctrl_state_e      state;
        logic             start_n;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] tmo;
        logic             valid;
        logic             err;
        logic [OUT_W-1:0] data;
    } ctrl_t;

    ctrl_t            q, d;
    logic             conv_idle_s;
    logic             fire_ok;
    logic             issue;
    logic [OUT_W-1:0] fmt_word;

    adc_sync2 #(.RST_VAL(1'b1)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (adc_busy_n),
        .q_o (conv_idle_s)
    );

    adc_pacer #(.CNT_W(CNT_W), .MIN_GAP(MIN_GAP_CYC)) i_pacer (
        .clk        (clk),
        .rst        (rst),
        .auto_en    (auto_en),
        .interval_i (sample_interval),
        .trig_i     (sw_trig),
        .issue_i    (issue),
        .fire_ok_o  (fire_ok)
    );

    adc_fmt #(.DATA_W(DATA_W), .OUT_W(OUT_W), .OFFSET_BIN(OFFSET_BIN)) i_fmt (
        .raw_i  (adc_data),
        .word_o (fmt_word)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.err   = 1'b0;
        issue   = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (fire_ok && conv_idle_s) begin
                    issue     = 1'b1;
                    d.state   = ST_START_LOW;
                    d.start_n = 1'b0;
                    d.cnt     = LOW_L;
                    d.tmo     = '0;
                end
            end
            ST_START_LOW: begin
                d.tmo = q.tmo + ONE_L;
                if (q.cnt == '0) begin
                    d.start_n = 1'b1;
                    d.state   = ST_WAIT_LOW;
                end else begin
                    d.cnt = q.cnt - ONE_L;
                end
            end
            ST_WAIT_LOW: begin
                d.tmo = q.tmo + ONE_L;
                if (!conv_idle_s) begin
                    d.state = ST_WAIT_HIGH;
                end else if (q.tmo == TMO_L) begin
                    d.err   = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            ST_WAIT_HIGH: begin
                d.tmo = q.tmo + ONE_L;
                if (conv_idle_s) begin
                    d.state = ST_SETTLE;
                    d.cnt   = SETTLE_L;
                end else if (q.tmo == TMO_L) begin
                    d.err   = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            ST_SETTLE: begin
                if (q.cnt == '0) begin
                    d.state = ST_CAPTURE;
                    d.valid = 1'b1;
                    d.data  = fmt_word;
                end else begin
                    d.cnt = q.cnt - ONE_L;
                end
            end
            ST_CAPTURE: d.state = ST_IDLE;
            default:    d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state   <= ST_IDLE;
            q.start_n <= 1'b1;
            q.cnt     <= '0;
            q.tmo     <= '0;
            q.valid   <= 1'b0;
            q.err     <= 1'b0;
            q.data    <= '0;
        end else begin
            q <= d;
        end
    end

    assign adc_start_n = q.start_n;
    assign smp_valid   = q.valid;
    assign smp_data    = q.data;
    assign timeout_err = q.err;

endmodule

// File: rtl/adc_conv_ctrl_chk.sv
`timescale 1ns/1ps
module adc_conv_ctrl_chk #(
    parameter int DATA_W        = 14,
    parameter int OUT_W         = 16,
    parameter int CNT_W         = 16,
    parameter int START_LOW_CYC = 2,
    parameter int MIN_GAP       = 91,
    parameter int SETTLE        = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start_n,
    input logic              idle_s,
    input logic [DATA_W-1:0] adc_data,
    input logic              smp_valid,
    input logic [OUT_W-1:0]  smp_data,
    input logic              timeout_err
);

    localparam logic [CNT_W-1:0] SAT_L = '1;
    localparam logic [CNT_W-1:0] ONE_L = CNT_W'(1);

    logic [CNT_W-1:0] low_cnt, gap_cnt, hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            gap_cnt <= SAT_L;
            hi_cnt  <= '0;
        end else begin
            low_cnt <= start_n ? '0 : low_cnt + ONE_L;
            if (!start_n && $past(start_n))  gap_cnt <= ONE_L;
            else if (gap_cnt != SAT_L)       gap_cnt <= gap_cnt + ONE_L;
            if (!idle_s)                     hi_cnt  <= '0;
            else if (hi_cnt != SAT_L)        hi_cnt  <= hi_cnt + ONE_L;
        end
    end

    AST_NO_START_DURING_CONV: assert property (@(posedge clk) disable iff (rst)
        $fell(start_n) |-> $past(idle_s)); // R2

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(start_n) |-> (low_cnt == CNT_W'(START_LOW_CYC))); // R3

    AST_START_SPACING: assert property (@(posedge clk) disable iff (rst)
        $fell(start_n) |-> (gap_cnt >= CNT_W'(MIN_GAP))); // R4

    AST_CAPTURE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> (hi_cnt >= CNT_W'(SETTLE))); // R5

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid); // R6

    AST_CAPTURED_WORD: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> (smp_data[DATA_W-2:0] == $past(adc_data[DATA_W-2:0]))); // R6

    AST_ERR_NO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> !smp_valid); // R9

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> !timeout_err); // R9

endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(
    .DATA_W        (DATA_W),
    .OUT_W         (OUT_W),
    .CNT_W         (CNT_W),
    .START_LOW_CYC (START_LOW_CYC),
    .MIN_GAP       (MIN_GAP_CYC),
    .SETTLE        (SETTLE_CYC)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .start_n     (adc_start_n),
    .idle_s      (conv_idle_s),
    .adc_data    (adc_data),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .timeout_err (timeout_err)
);

// File: tb/test_adc_conv_ctrl.sv
`timescale 1ns/1ps
module test_adc_conv_ctrl;

    localparam int CLK_PS = 5000;
    localparam int SETTLE = (20000 + CLK_PS - 1) / CLK_PS;
    localparam int GAP    = (454000 + CLK_PS - 1) / CLK_PS;
    localparam int TMO    = (400000 + CLK_PS - 1) / CLK_PS + 8;
    localparam int LOWC   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        auto_en = 1'b0;
    logic        sw_trig = 1'b0;
    logic        adc_busy_n = 1'b1;
    logic [15:0] sample_interval = '0;
    logic [13:0] adc_data = '0;

    logic        adc_start_n, adc_start_n_ob;
    logic        smp_valid, smp_valid_ob;
    logic        timeout_err, timeout_err_ob;
    logic [15:0] smp_data, smp_data_ob;

    int n_checks = 0, n_fail = 0, cyc = 0;
    int last_fall = 0, last_gap = 0, n_falls = 0, n_bad = 0, n_valid = 0, n_err = 0;
    bit prev_sn = 1'b1, done = 1'b0;

    always #2.5 clk = ~clk;

    adc_conv_ctrl #(.OFFSET_BIN(1'b0)) i_adc_conv_ctrl (
        .clk(clk), .rst(rst), .auto_en(auto_en), .sample_interval(sample_interval),
        .sw_trig(sw_trig), .adc_start_n(adc_start_n), .adc_busy_n(adc_busy_n),
        .adc_data(adc_data), .smp_valid(smp_valid), .smp_data(smp_data),
        .timeout_err(timeout_err));

    adc_conv_ctrl #(.OFFSET_BIN(1'b1)) i_adc_conv_ctrl_ob (
        .clk(clk), .rst(rst), .auto_en(auto_en), .sample_interval(sample_interval),
        .sw_trig(sw_trig), .adc_start_n(adc_start_n_ob), .adc_busy_n(adc_busy_n),
        .adc_data(adc_data), .smp_valid(smp_valid_ob), .smp_data(smp_data_ob),
        .timeout_err(timeout_err_ob));

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (prev_sn && !adc_start_n) begin
            last_gap  = cyc - last_fall;
            last_fall = cyc;
            n_falls++;
            if (!adc_busy_n) n_bad++;
        end
        prev_sn = adc_start_n;
        if (smp_valid)   n_valid++;
        if (timeout_err) n_err++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_trig();
        @(negedge clk) sw_trig = 1'b1;
        @(negedge clk) sw_trig = 1'b0;
    endtask

    // Converter model: busy drops just after the strobe, a decoy word sits on
    // the bus, then the true word appears together with the busy rise.
    task automatic run_conv(input logic [13:0] w, input int conv, input bit poke);
        int g = 0;
        int wdt, lat, s;
        logic [15:0] e_sx, e_ob;
        while (adc_start_n === 1'b1 && g < 3000) begin @(negedge clk); g++; end
        #1 adc_busy_n = 1'b0;
        adc_data = w ^ 14'h1555;
        wdt = 1;
        @(negedge clk);
        while (!adc_start_n && wdt < 50) begin wdt++; @(negedge clk); end
        chk(wdt == LOWC, "R3 strobe low width", wdt, LOWC);
        repeat (conv) begin @(negedge clk); sw_trig = poke; end
        @(negedge clk);
        sw_trig    = 1'b0;
        adc_data   = w;
        adc_busy_n = 1'b1;
        lat = 0;
        do begin @(posedge clk); lat++; @(negedge clk); end while (!smp_valid && lat < 40);
        chk(lat == SETTLE + 3, "R5 capture latency after busy rise", lat, SETTLE + 3);
        s    = (w >= 14'd8192) ? int'(w) - 16384 : int'(w);
        e_sx = 16'(s);
        e_ob = 16'(s + 8192);
        chk(smp_data == e_sx, "R6 sign-extended word", int'(smp_data), int'(e_sx));
        chk(smp_data_ob == e_ob, "R7 offset-binary word", int'(smp_data_ob), int'(e_ob));
        @(negedge clk);
        chk(!smp_valid, "R6 valid single cycle", int'(smp_valid), 0);
    endtask

    task automatic tmo_case(input bit drop);
        int g = 0, n = 0;
        pulse_trig();
        while (adc_start_n === 1'b1 && g < 3000) begin @(negedge clk); g++; end
        if (drop) #1 adc_busy_n = 1'b0;
        do begin @(posedge clk); n++; @(negedge clk); end while (!timeout_err && n < 300);
        chk(n == TMO + 1, "R9 timeout cycle", n, TMO + 1);
        chk(!smp_valid, "R9 no sample on timeout", int'(smp_valid), 0);
        @(negedge clk);
        chk(!timeout_err, "R9 error single cycle", int'(timeout_err), 0);
    endtask

    initial begin
        logic [13:0] corners [6];
        int f0, v0, e0;
        corners[0] = 14'h0000; corners[1] = 14'h0001; corners[2] = 14'h1FFF;
        corners[3] = 14'h2000; corners[4] = 14'h3FFF; corners[5] = 14'h2001;

        repeat (3) @(negedge clk);
        chk(adc_start_n, "R1 reset strobe high", int'(adc_start_n), 1);
        chk(!smp_valid, "R1 reset no valid", int'(smp_valid), 0);
        chk(!timeout_err, "R1 reset no error", int'(timeout_err), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R10: immediate response from idle
        pulse_trig();
        chk(!adc_start_n, "R10 strobe falls after trigger", int'(adc_start_n), 0);

        // Data sweep, triggers back to back: spacing is enforced (R4)
        for (int i = 0; i < 70; i++) begin
            logic [13:0] w;
            w = (i < 6) ? corners[i] : 14'(i * 613 + 37);
            if (i > 0) pulse_trig();
            run_conv(w, 12 + (i % 40), 1'b0);
            if (i > 0) chk(last_gap == GAP, "R4 pending trigger spacing", last_gap, GAP);
        end

        // R2: trigger held during a conversion, then served at the spacing
        pulse_trig();
        run_conv(14'h0ABC, 40, 1'b1);
        run_conv(14'h3456, 30, 1'b0);
        chk(last_gap == GAP, "R2 held trigger served", last_gap, GAP);

        // R8: free-running mode
        sample_interval = 16'd150;
        auto_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            run_conv(14'(k * 3001 + 5), 40, 1'b0);
            if (k > 0) chk(last_gap == 150, "R8 interval spacing", last_gap, 150);
        end
        sample_interval = 16'd10;
        for (int k = 0; k < 3; k++) begin
            run_conv(14'(k * 4111 + 9), 40, 1'b0);
            if (k > 0) chk(last_gap == GAP, "R8 short interval floored", last_gap, GAP);
        end
        auto_en = 1'b0;

        // R9: busy never falls, then busy never rises
        repeat (120) @(negedge clk);
        tmo_case(1'b0);
        repeat (120) @(negedge clk);
        tmo_case(1'b1);

        // R2: no start while busy stays low; pending request served afterwards
        f0 = n_falls;
        pulse_trig();
        repeat (120) @(negedge clk);
        chk(n_falls == f0, "R2 no start while busy low", n_falls, f0);
        adc_busy_n = 1'b1;
        run_conv(14'h1234, 30, 1'b0);

        // R1: reset mid-conversion
        repeat (120) @(negedge clk);
        pulse_trig();
        while (adc_start_n) @(negedge clk);
        #1 adc_busy_n = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(adc_start_n, "R1 mid-run reset strobe high", int'(adc_start_n), 1);
        chk(!smp_valid, "R1 mid-run reset no valid", int'(smp_valid), 0);
        adc_busy_n = 1'b1;
        rst = 1'b0;
        v0 = n_valid;
        e0 = n_err;
        repeat (150) @(negedge clk);
        chk(n_valid == v0, "R1 no stale sample after reset", n_valid, v0);
        chk(n_err == e0, "R1 no stale timeout after reset", n_err, e0);
        pulse_trig();
        run_conv(14'h2AAA, 25, 1'b0);

        chk(n_bad == 0, "R2 no start edge during busy", n_bad, 0);
        chk(n_err == 2, "R9 timeout count", n_err, 2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule